// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Register

This block collects single-cycle event pulses from a network MAC and holds each one in a sticky status bit until software reads it. The status word and a mask word sit behind a small register port. That port has a select strobe, a read strobe, a write strobe and one address bit. Reading the status returns every bit that is set and clears those same bits in the same access. The mask is an ordinary read/write register. A mask bit of one keeps its source off the interrupt line.

The block drives one level-sensitive interrupt request. The request is high while any status bit is set whose mask bit is zero. After reset the mask is all ones, so no source can raise the request until software opens at least one mask bit. Each source has a fixed bit position:

| Bit | Source |
|-----|--------|
| 0 | transmit done |
| 1 | receive done |
| 2 | missed-packet counter overflow |
| 3 | runt counter overflow |
| 4 | receive-collision counter overflow |
| 5 | collision error |
| 6 | babble error |
| 7 | jabber error |

Top module: `mac_irq_status`

## Requirements
- R1: After reset the status word is 0x00, the mask word is 0xFF, the interrupt request is low and the read data output is 0x00.
- R2: A one on event input k sets status bit k at the next clock edge. The bit stays set after the pulse ends, until a status read clears it. Bit 7 is jabber, 6 babble, 5 collision error, 4 receive-collision overflow, 3 runt overflow, 2 missed-packet overflow, 1 receive done and 0 transmit done.
- R3: A read with select high and address 0 (status) loads the current raw status into the read data output at that clock edge. The mask has no effect on this value.
- R4: A status read clears the bits it returned. An event that arrives in the same cycle as the read leaves its bit set afterwards.
- R5: A write with select high and address 1 stores the write data as the mask. A read with select high and address 1 returns the mask and changes nothing.
- R6: The interrupt request equals the OR of (status AND NOT mask). It follows a status or mask change in the same cycle that the register changes.
- R7: While the mask is 0xFF, the interrupt request is low whatever the status holds.
- R8: Read or write strobes with select low have no effect. A write to address 0 does not change the status.
- R9: The read data output holds its value until the next read with select high.

Ports are listed below in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event pulses, one per source |
| sel_i | input | 1 | Register access select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 1 | 0 = status, 1 = mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a status read that coincides with a new event. That edge must return the old bits and must also keep the new bit set. The scoreboard driver reaches it by raising an event pulse in the same cycle as the read strobe. A second read then checks that only the new bit remains. A further hard case is the masked-but-pending state. The bench sets status bits while the mask is closed. It confirms that the interrupt stays low and that a read still returns the raw bits. It then opens and closes single mask bits around a pending source.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;

   // Number of named interrupt sources
   localparam int unsigned IRQ_SRC_COUNT = 8;

   // Fixed source positions within the status and mask words
   typedef enum logic [2:0] {
      SRC_TX_DONE    = 3'd0,
      SRC_RX_DONE    = 3'd1,
      SRC_MISS_OVF   = 3'd2,
      SRC_RUNT_OVF   = 3'd3,
      SRC_RXCOL_OVF  = 3'd4,
      SRC_COLL_ERR   = 3'd5,
      SRC_BABBLE     = 3'd6,
      SRC_JABBER     = 3'd7
   } irq_src_e;

   // Register selection by address bit
   typedef enum logic {
      REG_STATUS = 1'b0,
      REG_MASK   = 1'b1
   } reg_sel_e;

endpackage

// File: rtl/mac_irq_stat_bit.sv
module mac_irq_stat_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic stat_o
);

   logic stat_q;

   // Clear on read, but a same-cycle event wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
      end else begin
         stat_q <= (stat_q & ~clr_i) | evt_i;
      end
   end

   assign stat_o = stat_q;

   // R2
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> stat_o);

   // R2
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o && !clr_i) |=> stat_o);

   // R4
   clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> !stat_o);

endmodule

// File: rtl/mac_irq_mask_reg.sv
module mac_irq_mask_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);

   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= RST_VAL;
      end else if (wr_en_i) begin
         mask_q <= wdata_i;
      end
   end

   assign mask_o = mask_q;

   // R5
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(mask_o));

endmodule

// File: rtl/mac_irq_rd_port.sv
module mac_irq_rd_port
   import mac_irq_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_en_i,
   input  reg_sel_e     reg_sel_i,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] rdata_o
);

   logic [W-1:0] rdata_q;
   logic [W-1:0] rd_mux;

   always_comb begin
      unique case (reg_sel_i)
         REG_STATUS: rd_mux = stat_i;
         REG_MASK:   rd_mux = mask_i;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en_i) begin
         rdata_q <= rd_mux;
      end
   end

   assign rdata_o = rdata_q;

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
   import mac_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = IRQ_SRC_COUNT,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               sel_i,
   input  logic               rd_i,
   input  logic               wr_i,
   input  logic               addr_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] rdata_o,
   output logic               irq_o
);

   localparam int unsigned W = NUM_SRC;
   localparam logic [W-1:0] MASK_RST = {W{1'b1}};

   // Elaboration-time parameter checks
   if (NUM_SRC < IRQ_SRC_COUNT) begin : g_bad_width
      $error("NUM_SRC must cover all named sources");
   end

   reg_sel_e     reg_sel;
   logic         stat_rd;
   logic         mask_wr;
   logic         any_rd;
   logic [W-1:0] stat_vec;
   logic [W-1:0] mask_vec;
   logic [W-1:0] pend_vec;

   assign reg_sel = reg_sel_e'(addr_i);
   assign any_rd  = sel_i & rd_i;
   assign stat_rd = any_rd & (reg_sel == REG_STATUS);
   assign mask_wr = sel_i & wr_i & (reg_sel == REG_MASK);

   for (genvar k = 0; k < W; k++) begin : g_stat
      mac_irq_stat_bit u_bit (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (evt_i[k]),
         .clr_i  (stat_rd),
         .stat_o (stat_vec[k])
      );
   end

   mac_irq_mask_reg #(
      .W       (W),
      .RST_VAL (MASK_RST)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (mask_wr),
      .wdata_i (wdata_i),
      .mask_o  (mask_vec)
   );

   mac_irq_rd_port #(
      .W (W)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en_i   (any_rd),
      .reg_sel_i (reg_sel),
      .stat_i    (stat_vec),
      .mask_i    (mask_vec),
      .rdata_o   (rdata_o)
   );

   assign pend_vec = stat_vec & ~mask_vec;

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= |pend_vec;
         end
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |pend_vec;

      // R7
      mask_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_vec == MASK_RST) |-> !irq_o);

      // R6
      irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (stat_vec != '0) && (mask_vec != MASK_RST));
   end

   // R3
   stat_read_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (rdata_o == $past(stat_vec)));

   // R5
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_vec == $past(wdata_i)));

   // R8
   no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_i && evt_i == '0) |=> (stat_vec == $past(stat_vec)));

endmodule

// File: tb/mac_irq_status_tb.sv
module mac_irq_status_tb;

   localparam int unsigned W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] evt_i = '0;
   logic         sel_i = 1'b0;
   logic         rd_i = 1'b0;
   logic         wr_i = 1'b0;
   logic         addr_i = 1'b0;
   logic [W-1:0] wdata_i = '0;
   logic [W-1:0] rdata_o;
   logic         irq_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];
   logic         rd_seen = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   mac_irq_status u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i),
      .sel_i   (sel_i),
      .rd_i    (rd_i),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .irq_o   (irq_o)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   // Monitor: pop the expected read data one negedge after the read edge
   always @(posedge clk) rd_seen <= sel_i & rd_i;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            check("monitor: unexpected read", 8'h00, 8'hFF);
         end else begin
            check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
         end
      end
   end

   // Driver tasks: all inputs change on the falling edge
   task automatic do_read(input logic a, input logic [W-1:0] exp,
                          input logic [W-1:0] evt, input string tag);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      sel_i = 1'b1; rd_i = 1'b1; addr_i = a; evt_i = evt;
      @(negedge clk);
      sel_i = 1'b0; rd_i = 1'b0; evt_i = '0;
   endtask

   task automatic do_write(input logic s, input logic a, input logic [W-1:0] d);
      @(negedge clk);
      sel_i = s; wr_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
   endtask

   task automatic pulse(input logic [W-1:0] v);
      @(negedge clk);
      evt_i = v;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq after reset", {7'b0, irq_o}, 8'h00);
      check("R1 rdata after reset", rdata_o, 8'h00);
      do_read(1'b1, 8'hFF, '0, "R1 mask reset value");
      do_read(1'b0, 8'h00, '0, "R1 status reset value");

      // R2/R3/R6: jabber (bit 7) while mask closed
      pulse(8'h80);
      check("R6 masked source keeps irq low", {7'b0, irq_o}, 8'h00);
      do_read(1'b0, 8'h80, '0, "R3 raw status ignores mask");
      do_read(1'b0, 8'h00, '0, "R4 read cleared returned bits");

      // R5 mask write and readback
      do_write(1'b1, 1'b1, 8'h00);
      do_read(1'b1, 8'h00, '0, "R5 mask readback");

      // R2/R6: receive done (bit 1), sticky
      pulse(8'h02);
      check("R6 open source raises irq", {7'b0, irq_o}, 8'h01);
      idle(3);
      check("R2 status bit sticky", {7'b0, irq_o}, 8'h01);
      do_write(1'b1, 1'b1, 8'h02);
      check("R6 mask bit blocks source", {7'b0, irq_o}, 8'h00);
      do_write(1'b1, 1'b1, 8'hFD);
      check("R6 other bits masked, source open", {7'b0, irq_o}, 8'h01);
      do_write(1'b1, 1'b1, 8'hFF);
      check("R7 all-ones mask silences irq", {7'b0, irq_o}, 8'h00);
      do_read(1'b0, 8'h02, '0, "R2 receive-done bit held");

      // R4: event in the same cycle as the status read
      pulse(8'h01);
      do_read(1'b0, 8'h01, 8'h20, "R4 read returns old bits");
      do_read(1'b0, 8'h20, '0, "R4 same-cycle event kept");
      do_read(1'b0, 8'h00, '0, "R4 cleared after second read");

      // R8: strobes without select
      pulse(8'h10);
      do_write(1'b0, 1'b1, 8'h00);
      @(negedge clk);
      sel_i = 1'b0; rd_i = 1'b1; addr_i = 1'b0;
      @(negedge clk);
      rd_i = 1'b0;
      check("R9 rdata held without select", rdata_o, 8'h00);
      do_read(1'b1, 8'hFF, '0, "R8 unselected write ignored");
      do_write(1'b1, 1'b0, 8'h00);
      do_read(1'b0, 8'h10, '0, "R8 unselected read and status write ignored");

      // R2: several sources at once, unmasked irq
      do_write(1'b1, 1'b1, 8'hF7);
      pulse(8'h5C);
      check("R6 runt overflow unmasked", {7'b0, irq_o}, 8'h01);
      do_read(1'b0, 8'h5C, '0, "R2 multi-source pattern");
      check("R6 irq drops after clear", {7'b0, irq_o}, 8'h00);
      idle(2);
      check("R9 rdata holds last value", rdata_o, 8'h5C);

      idle(2);
      if (exp_q.size() != 0) check("monitor drain", 8'h01, 8'h00);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule